// File: doc/BRIEF.md
# Region-Based Address Translator

The block turns a virtual address plus an access kind (read, write or execute) into a real address. It does this by scanning a short list of region descriptors that software has loaded into an internal table. Each descriptor takes three consecutive words. The first word carries the region length in its upper bits and three access-right bits in its low bits. The second word is the virtual base of the region and the third word is the real base. A descriptor whose first word is all zeros marks the end of the list.

A request is accepted through a valid/ready handshake. A small state machine then examines one descriptor per clock cycle, in list order. It stops at the first region that contains the address, at the end marker, or at the last table slot. The result is then held on a valid/ready response channel until it is taken. The result is either a translated address or a fault, and the fault says whether the address matched no region or matched one whose rights forbid the access. Only one request is in flight at a time.

The table is filled through a single-word write port, one word per cycle, while the walker is idle.

Top module: `region_xlate`

## Requirements
- R1: The table is written one word per cycle through `tbl_we`/`tbl_addr`/`tbl_wdata`. Word index 3*d+0 is the first word of descriptor d, 3*d+1 its virtual base and 3*d+2 its real base, for d from 0 to 15. Reset clears every table word to zero.
- R2: Descriptor d contains address A when vbase <= A and (A - vbase) < size, where size is first word with its low three bits cleared.
- R3: On a permitted hit, `rsp_addr` = A - vbase + rbase (modulo 2^32), and both fault flags are 0.
- R4: The first containing descriptor in list order decides the outcome, even if a later descriptor would also contain the address.
- R5: A descriptor whose first word is zero ends the list with a miss. Descriptors after it have no effect.
- R6: Access-kind codes are 0 = read, 1 = write, 2 = execute, and 3 = never permitted. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. A hit whose bit is clear returns `rsp_perm_fault`=1, `rsp_miss`=0 and `rsp_addr`=0.
- R7: A miss returns `rsp_miss`=1, `rsp_perm_fault`=0 and `rsp_addr`=0. The two fault flags are never both set.
- R8: When descriptor k (counting from 0) decides the outcome, `rsp_valid` rises k+1 cycles after the accepting clock edge. If none of the 16 slots is an end marker or a hit, the result is a miss after 16 cycles.
- R9: `req_ready` is 1 only when no request is in flight, including right after reset. While `rsp_valid`=1 and `rsp_ready`=0, the response stays unchanged and a presented request is not accepted.
- R10: A descriptor with a nonzero first word whose upper bits are zero (size 0) contains no address and does not end the list. The low three bits never add to the region size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table word write enable |
| tbl_addr | input | 6 | Table word index (3*descriptor + field) |
| tbl_wdata | input | 32 | Table word data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_addr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_addr | output | 32 | Real address, zero on a fault |
| rsp_miss | output | 1 | No containing region found |
| rsp_perm_fault | output | 1 | Region found but access kind not allowed |

## Verification
The hardest outcome to reach from the ports is a walk that runs through all sixteen slots with no end marker. That case needs the whole table filled with live, non-containing regions. The bench builds it on purpose: it fills every slot with such regions and then sends a miss and a hit on the final slot. A request presented while a result is held back is also hard to produce, so the bench stalls `rsp_ready` with a conflicting request driven and then confirms that the walker comes back idle instead of starting a second walk. Overlapping regions with different rights, zero-length entries and entries after a terminator are placed in a directed table. Randomly built tables with random terminator positions cover the rest.

// File: rtl/region_xlate_pkg.sv
package region_xlate_pkg;

  // access kind: value selects which permission bit applies
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } wstate_e;

  localparam int PERM_BITS = 3;
  localparam int WORDS_PER_DESC = 3;

endpackage

// File: rtl/rx_table.sv
module rx_table #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 16,
  parameter int WA_W     = 6,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WA_W-1:0]   waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_head,
  output logic [ADDR_W-1:0] rd_vbase,
  output logic [ADDR_W-1:0] rd_rbase
);
  import region_xlate_pkg::*;

  logic [ADDR_W-1:0] head_q  [MAX_DESC];
  logic [ADDR_W-1:0] vbase_q [MAX_DESC];
  logic [ADDR_W-1:0] rbase_q [MAX_DESC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < MAX_DESC; d++) begin
        head_q[d]  <= '0;
        vbase_q[d] <= '0;
        rbase_q[d] <= '0;
      end
    end else if (we) begin
      for (int d = 0; d < MAX_DESC; d++) begin
        if (waddr == WA_W'(WORDS_PER_DESC*d))     head_q[d]  <= wdata;
        if (waddr == WA_W'(WORDS_PER_DESC*d + 1)) vbase_q[d] <= wdata;
        if (waddr == WA_W'(WORDS_PER_DESC*d + 2)) rbase_q[d] <= wdata;
      end
    end
  end

  assign rd_head  = head_q[rd_idx];
  assign rd_vbase = vbase_q[rd_idx];
  assign rd_rbase = rbase_q[rd_idx];

endmodule

// File: rtl/rx_match.sv
module rx_match #(
  parameter int ADDR_W = 32
) (
  input  logic              [ADDR_W-1:0] addr,
  input  region_xlate_pkg::acc_e         kind,
  input  logic              [ADDR_W-1:0] head,
  input  logic              [ADDR_W-1:0] vbase,
  input  logic              [ADDR_W-1:0] rbase,
  output logic                           is_end,
  output logic                           is_hit,
  output logic                           perm_ok,
  output logic              [ADDR_W-1:0] xaddr
);
  import region_xlate_pkg::*;

  function automatic logic [ADDR_W-1:0] region_len(input logic [ADDR_W-1:0] w);
    return {w[ADDR_W-1:PERM_BITS], {PERM_BITS{1'b0}}};
  endfunction

  // subtract-then-compare: no overflow of vbase+size
  function automatic logic contains(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W-1:0] len);
    return (a >= base) && ((a - base) < len);
  endfunction

  function automatic logic kind_allowed(input logic [PERM_BITS-1:0] p, input acc_e k);
    case (k)
      ACC_READ:  return p[0];
      ACC_WRITE: return p[1];
      ACC_EXEC:  return p[2];
      default:   return 1'b0;
    endcase
  endfunction

  assign is_end  = (head == '0);
  assign is_hit  = contains(addr, vbase, region_len(head));
  assign perm_ok = kind_allowed(head[PERM_BITS-1:0], kind);
  assign xaddr   = addr - vbase + rbase;

endmodule

// File: rtl/rx_walker.sv
module rx_walker #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 16,
  parameter int IDX_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_kind,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [ADDR_W-1:0]      rsp_addr,
  output logic                   rsp_miss,
  output logic                   rsp_perm_fault,
  output logic [IDX_W-1:0]       idx,
  output logic [ADDR_W-1:0]      cur_addr,
  output region_xlate_pkg::acc_e cur_kind,
  output logic                   walking,
  input  logic                   desc_end,
  input  logic                   desc_hit,
  input  logic                   desc_perm_ok,
  input  logic [ADDR_W-1:0]      desc_xaddr
);
  import region_xlate_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DESC - 1);

  wstate_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      idx            <= '0;
      cur_addr       <= '0;
      cur_kind       <= ACC_READ;
      rsp_addr       <= '0;
      rsp_miss       <= 1'b0;
      rsp_perm_fault <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_kind <= acc_e'(req_kind);
          idx      <= '0;
          state    <= ST_WALK;
        end
        ST_WALK: begin
          if (desc_end || (!desc_hit && idx == LAST_IDX)) begin
            rsp_miss       <= 1'b1;
            rsp_perm_fault <= 1'b0;
            rsp_addr       <= '0;
            state          <= ST_RESP;
          end else if (desc_hit) begin
            rsp_miss       <= 1'b0;
            rsp_perm_fault <= !desc_perm_ok;
            rsp_addr       <= desc_perm_ok ? desc_xaddr : '0;
            state          <= ST_RESP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign walking   = (state == ST_WALK);

endmodule

// File: rtl/region_xlate.sv
module region_xlate #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 16,
  localparam int WORDS   = 3 * MAX_DESC,
  localparam int WA_W    = $clog2(WORDS),
  localparam int IDX_W   = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [WA_W-1:0]   tbl_addr,
  input  logic [ADDR_W-1:0] tbl_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_miss,
  output logic              rsp_perm_fault
);
  import region_xlate_pkg::*;

  // named internal events, observed by the bound checker
  logic [IDX_W-1:0]  walk_idx;
  logic [ADDR_W-1:0] cur_addr;
  acc_e              cur_kind;
  logic              walking;
  logic [ADDR_W-1:0] d_head, d_vbase, d_rbase;
  logic              desc_end, desc_hit, desc_perm_ok;
  logic [ADDR_W-1:0] desc_xaddr;

  rx_table #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC), .WA_W(WA_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .rd_idx(walk_idx), .rd_head(d_head), .rd_vbase(d_vbase), .rd_rbase(d_rbase)
  );

  rx_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(cur_addr), .kind(cur_kind), .head(d_head), .vbase(d_vbase), .rbase(d_rbase),
    .is_end(desc_end), .is_hit(desc_hit), .perm_ok(desc_perm_ok), .xaddr(desc_xaddr)
  );

  rx_walker #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_miss(rsp_miss), .rsp_perm_fault(rsp_perm_fault),
    .idx(walk_idx), .cur_addr(cur_addr), .cur_kind(cur_kind), .walking(walking),
    .desc_end(desc_end), .desc_hit(desc_hit), .desc_perm_ok(desc_perm_ok),
    .desc_xaddr(desc_xaddr)
  );

endmodule

// File: rtl/region_xlate_chk.sv
module region_xlate_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_miss,
  input logic              rsp_perm_fault,
  input logic              walking,
  input logic              desc_hit,
  input logic              desc_end
);
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  logic [CNT_W-1:0] walk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   walk_cnt <= '0;
    else if (req_valid && req_ready) walk_cnt <= '0;
    else if (walking)             walk_cnt <= walk_cnt + 1'b1;
  end

  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> walk_cnt < CNT_W'(MAX_DESC)); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_miss)
                                && $stable(rsp_perm_fault)); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_miss && rsp_perm_fault)); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_miss || rsp_perm_fault) |-> rsp_addr == '0); // R6

  AST_FIRST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    walking && desc_hit && !desc_end |=> rsp_valid && !rsp_miss); // R4

  AST_END_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    walking && desc_end |=> rsp_valid && rsp_miss); // R5

endmodule

bind region_xlate region_xlate_chk #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_miss(rsp_miss), .rsp_perm_fault(rsp_perm_fault), .walking(walking),
  .desc_hit(desc_hit), .desc_end(desc_end)
);

// File: tb/region_xlate_bench.sv
module region_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_addr;
  logic        rsp_miss;
  logic        rsp_perm_fault;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] m_head [NDESC];
  logic [31:0] m_vb   [NDESC];
  logic [31:0] m_rb   [NDESC];

  region_xlate u_region_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_miss(rsp_miss), .rsp_perm_fault(rsp_perm_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_desc(input int d, input logic [31:0] h, input logic [31:0] v,
                          input logic [31:0] r);
    wr_word(3*d, h); wr_word(3*d+1, v); wr_word(3*d+2, r);
    m_head[d] = h; m_vb[d] = v; m_rb[d] = r;
  endtask

  task automatic clear_table();
    for (int d = 0; d < NDESC; d++) set_desc(d, 32'h0, 32'h0, 32'h0);
  endtask

  // independent restatement of the walk: returns decision index and outcome
  task automatic model(input logic [31:0] a, input logic [1:0] k, output logic [31:0] ea,
                       output logic em, output logic ep, output int elat);
    ea = '0; em = 1'b1; ep = 1'b0; elat = NDESC;
    for (int d = 0; d < NDESC; d++) begin
      logic [31:0] len;
      len = m_head[d] & ~32'h7;
      if (m_head[d] == 32'h0) begin
        elat = d + 1; return;
      end
      if (a >= m_vb[d] && (a - m_vb[d]) < len) begin
        logic ok;
        ok = (k == 2'd3) ? 1'b0 : m_head[d][k];
        elat = d + 1; em = 1'b0; ep = !ok;
        ea = ok ? (a - m_vb[d] + m_rb[d]) : 32'h0;
        return;
      end
    end
  endtask

  task automatic run_req(input logic [31:0] a, input logic [1:0] k, input int hold,
                         input string req);
    logic [31:0] ea; logic em, ep; int elat; int lat;
    model(a, k, ea, em, ep, elat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "latency", 32'(lat), 32'(elat));
    chk(req, "rsp_addr", rsp_addr, ea);
    chk(req, "rsp_miss", 32'(rsp_miss), 32'(em));
    chk(req, "rsp_perm_fault", 32'(rsp_perm_fault), 32'(ep));
    if (hold > 0) begin
      req_valid = 1'b1; req_addr = ~a; req_kind = 2'd0;
      repeat (hold) @(negedge clk);
      chk("R9", "held rsp_addr", rsp_addr, ea);
      chk("R9", "held rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R9", "req_ready while held", 32'(req_ready), 32'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    if (hold > 0) begin
      chk("R9", "idle after take rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R9", "idle after take req_ready", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < NDESC; d++) begin
      m_head[d] = '0; m_vb[d] = '0; m_rb[d] = '0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    // R1: reset-cleared table ends at slot 0 (R5)
    run_req(32'h1234, 2'd0, 0, "R1");

    // directed table
    set_desc(0, 32'h0000_0100 | 32'h1, 32'h1000, 32'h8000_0000);        // read only
    set_desc(1, 32'h0000_0100 | 32'h7, 32'h1080, 32'h9000_0000);        // overlaps, all rights
    set_desc(2, 32'h0000_0007,        32'h0000, 32'h4444_0000);        // size 0 (R10)
    set_desc(3, 32'h0000_0010 | 32'h6, 32'h2000, 32'hFFFF_FFF8);        // low bits not size
    set_desc(4, 32'h0,                32'h0,    32'h0);                // end marker
    set_desc(5, 32'h0000_0100 | 32'h7, 32'h5000, 32'h7000_0000);        // after end

    run_req(32'h1000, 2'd0, 0, "R3");   // base of d0
    run_req(32'h10FF, 2'd0, 0, "R2");   // last byte of d0
    run_req(32'h1100, 2'd1, 0, "R2");   // just past d0, inside d1
    run_req(32'h1080, 2'd1, 0, "R4");   // overlap: d0 decides, write denied
    run_req(32'h1080, 2'd0, 0, "R4");   // overlap: d0 translation
    run_req(32'h1000, 2'd3, 0, "R6");   // kind 3 never allowed
    run_req(32'h2008, 2'd2, 0, "R6");   // execute allowed, wraps real address (R3)
    run_req(32'h200F, 2'd1, 0, "R10");  // last byte of 16-byte region
    run_req(32'h2010, 2'd1, 0, "R10");  // size not widened by perm bits -> miss
    run_req(32'h0000, 2'd0, 0, "R10");  // zero-size entry does not contain 0
    run_req(32'h5000, 2'd0, 0, "R5");   // region after end marker ignored
    run_req(32'h0FFF, 2'd0, 0, "R7");   // below every base: miss
    run_req(32'h1004, 2'd0, 4, "R9");   // stalled response, conflicting request ignored

    // R8: full table, no end marker
    for (int d = 0; d < NDESC; d++)
      set_desc(d, 32'h40 | 32'h3, 32'h10000 + 32'(d) * 32'h100, 32'h20000 + 32'(d) * 32'h1000);
    run_req(32'h0000_0004, 2'd0, 0, "R8");                  // miss after all 16
    run_req(32'h10000 + 32'hF00 + 32'h3C, 2'd1, 0, "R8");   // hit in last slot
    run_req(32'h10000 + 32'h33, 2'd2, 2, "R6");             // exec denied, stalled

    // R1/R2/R3: random tables and requests
    for (int t = 0; t < 12; t++) begin
      for (int d = 0; d < NDESC; d++) begin
        logic [31:0] h;
        h = (32'($urandom % 9) * 32'h8) | 32'($urandom % 8);
        if ($urandom % 7 == 0) h = 32'h0;
        set_desc(d, h, 32'($urandom % 32) * 32'h20, $urandom);
      end
      for (int q = 0; q < 20; q++)
        run_req(32'($urandom % 1100), 2'($urandom % 4), int'($urandom % 3), "R2");
    end

    report();
    $finish;
  end

endmodule